// File: doc/BRIEF.md
# Vector Element-Group GHASH Sequencer

This block runs the Galois-field hash multiply across a slice of a vector register file, one 128-bit element group at a time. It takes a decoded-instruction bundle: the raw 32-bit instruction word, the element-width code, the vector length and the start index. It picks one of two operations. A hash step folds a data block into an accumulator and multiplies the sum by a subkey. A plain multiply multiplies the accumulator by the subkey.

For every group it reads its operands through a single synchronous read port and starts a bit-serial multiplier in GF(2^128). When the multiplier reports completion, the sequencer writes the product back to the destination group it read. Only one group is in flight at a time. After the last group it pulses completion together with a request to clear the start index. An instruction that does not decode, or that carries the wrong element width, is refused with a one-cycle illegal pulse and touches nothing.

The register file sits outside the block as an array of 128-bit groups. Register r, group g lives at address r*(VLEN/128)+g, so a group index beyond one register runs on into the following registers. Element 4g+k of a group occupies bits 32k+31..32k of that word.

Top module: `ghash_group_seq`

## Requirements
- R1: An instruction is accepted as a hash step when bits 6..0 are 1110111, bits 14..12 are 010 and bits 31..25 are 1011001. Bits 11..7 name the destination, bits 19..15 the data source and bits 24..20 the subkey source.
- R2: An instruction is accepted as a plain multiply only if it has the same opcode and funct3, bits 31..25 equal 1010001 and bits 19..15 equal 10001. Any other pattern in those five bits makes it illegal.
- R3: With an element-width code other than 3'b010 (32-bit), or with an encoding matching neither operation, `illegal` pulses for one cycle in the cycle after `start`. No register-file write occurs, `done` and `vstart_clr` stay low, and the block returns to idle.
- R4: The groups processed are start/4 up to vl/4-1, each exactly once and in ascending order. Groups outside this range are never written.
- R5: In a hash step, each destination group becomes rev(M(rev(Y xor X), rev(H))). Y is the old destination group, X the data group and H the subkey group. rev reverses the bit order inside every byte. M is the product in GF(2^128): bit b of the first operand, taken from b=0 upward, adds the running second operand. The running second operand then shifts up one bit, and when its bit 127 was set, 0x87 is folded into its low byte.
- R6: In a plain multiply, each destination group becomes rev(M(rev(Y), rev(H))), and the data source is not read.
- R7: When start/4 is not below vl/4, nothing is read or written, but `done` and `vstart_clr` still pulse.
- R8: At the end of every legal operation `done` and `vstart_clr` are high together for exactly one cycle. `busy` is low in the following cycle.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: Writes never occur in two consecutive cycles, because each group waits for its own product before the next group begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse for the presented instruction |
| instr | input | 32 | Instruction word |
| vsew | input | 3 | Element-width code (3'b010 = 32 bits) |
| vl | input | VL_W | Vector length in elements |
| vstart | input | VL_W | Start element index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refusal pulse |
| vstart_clr | output | 1 | Request to clear the start index |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_addr | output | ADDR_W | Group address to read |
| rf_rd_data | input | 128 | Read data, valid one cycle after the request |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | ADDR_W | Group address to write |
| rf_wr_data | output | 128 | Group write data |

## Verification
The hardest case to reach from the ports is a second `start` that lands while a group is still inside the multiplier. To create it, the stimulus launches a long hash step and, three cycles later, presents an all-zero word that would be refused if it were decoded. The bench then requires that no illegal pulse appears, that exactly one completion occurs and that the register file matches the model of the first operation alone. The bounds of the group range are reached with start indices that are not multiples of four, lengths that span several registers, and ranges that are empty.

// File: rtl/ghash_seq_pkg.sv
package ghash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK_ACC,
        ST_TAKE_ACC,
        ST_TAKE_DAT,
        ST_TAKE_KEY,
        ST_MULT,
        ST_FINISH,
        ST_REJECT
    } seq_state_e;

    localparam logic [6:0] OPC_VEC      = 7'b1110111;
    localparam logic [2:0] FUNCT3_VV    = 3'b010;
    localparam logic [6:0] TOP_HASHSTEP = 7'b1011001;
    localparam logic [6:0] TOP_MULONLY  = 7'b1010001;
    localparam logic [4:0] MULONLY_RS1  = 5'b10001;
    localparam logic [2:0] SEW_32       = 3'b010;

    // Reverse bit order within each byte of a 128-bit word
    function automatic logic [127:0] byte_bitrev(input logic [127:0] v);
        logic [127:0] r;
        for (int i = 0; i < 128; i++) begin
            r[i] = v[(i & ~7) | (7 - (i & 7))];
        end
        return r;
    endfunction

    // Multiply by x in the field, reduction constant 0x87
    function automatic logic [127:0] gf_double(input logic [127:0] v);
        return {v[126:0], 1'b0} ^ (v[127] ? 128'h87 : 128'h0);
    endfunction

endpackage

// File: rtl/ghash_seq_decode.sv
module ghash_seq_decode
    import ghash_seq_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [2:0]  vsew,
    output logic        legal,
    output logic        mul_only,
    output logic [4:0]  vd,
    output logic [4:0]  vs1,
    output logic [4:0]  vs2
);
    logic base_ok;
    logic step_hit;
    logic mul_hit;

    always_comb begin
        base_ok  = (instr[6:0] == OPC_VEC) && (instr[14:12] == FUNCT3_VV);
        step_hit = base_ok && (instr[31:25] == TOP_HASHSTEP);
        mul_hit  = base_ok && (instr[31:25] == TOP_MULONLY) && (instr[19:15] == MULONLY_RS1);
        legal    = (step_hit || mul_hit) && (vsew == SEW_32);
        mul_only = mul_hit;
        vd       = instr[11:7];
        vs1      = instr[19:15];
        vs2      = instr[24:20];
    end
endmodule

// File: rtl/ghash_gf_mul.sv
module ghash_gf_mul
    import ghash_seq_pkg::*;
#(
    parameter int STEP_BITS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] a,
    input  logic [127:0] h,
    output logic         done,
    output logic [127:0] z
);
    localparam int STEPS  = 128 / STEP_BITS;
    localparam int CNT_W  = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [127:0]     s;
        logic [127:0]     h;
        logic [127:0]     z;
    } mul_t;

    mul_t q, d;
    logic [127:0] s_t, h_t, z_t;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        s_t   = q.s;
        h_t   = q.h;
        z_t   = q.z;
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.s   = a;
            d.h   = h;
            d.z   = '0;
        end else if (q.run) begin
            for (int k = 0; k < STEP_BITS; k++) begin
                if (s_t[k]) z_t = z_t ^ h_t;
                h_t = gf_double(h_t);
            end
            d.s   = s_t >> STEP_BITS;
            d.h   = h_t;
            d.z   = z_t;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.fin;
    assign z    = q.z;
endmodule

// File: rtl/ghash_group_seq.sv
module ghash_group_seq
    import ghash_seq_pkg::*;
#(
    parameter int VLEN      = 256,
    parameter int STEP_BITS = 8,
    localparam int GPR      = VLEN / 128,
    localparam int RF_GROUPS = 32 * GPR,
    localparam int ADDR_W   = $clog2(RF_GROUPS),
    localparam int VL_W     = $clog2(VLEN / 4) + 1,
    localparam int GI_W     = VL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [2:0]        vsew,
    input  logic [VL_W-1:0]   vl,
    input  logic [VL_W-1:0]   vstart,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              vstart_clr,
    output logic              rf_rd_en,
    output logic [ADDR_W-1:0] rf_rd_addr,
    input  logic [127:0]      rf_rd_data,
    output logic              rf_wr_en,
    output logic [ADDR_W-1:0] rf_wr_addr,
    output logic [127:0]      rf_wr_data
);
    typedef struct packed {
        seq_state_e      st;
        logic            mul_only;
        logic [4:0]      vd;
        logic [4:0]      vs1;
        logic [4:0]      vs2;
        logic [GI_W-1:0] gi;
        logic [GI_W-1:0] gend;
        logic [127:0]    acc;
        logic [127:0]    dat;
    } seq_t;

    seq_t q, d;

    logic         dec_legal, dec_mul;
    logic [4:0]   dec_vd, dec_vs1, dec_vs2;
    logic         mul_start, mul_done;
    logic [127:0] mul_z;
    logic [GI_W:0] gi_next;

    function automatic logic [ADDR_W-1:0] gaddr(input logic [4:0] r, input logic [GI_W-1:0] g);
        return ADDR_W'(int'(r) * GPR + int'(g));
    endfunction

    ghash_seq_decode u_dec (
        .instr    (instr),
        .vsew     (vsew),
        .legal    (dec_legal),
        .mul_only (dec_mul),
        .vd       (dec_vd),
        .vs1      (dec_vs1),
        .vs2      (dec_vs2)
    );

    ghash_gf_mul #(.STEP_BITS(STEP_BITS)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (byte_bitrev(q.acc ^ q.dat)),
        .h     (byte_bitrev(rf_rd_data)),
        .done  (mul_done),
        .z     (mul_z)
    );

    always_comb begin
        d          = q;
        rf_rd_en   = 1'b0;
        rf_rd_addr = '0;
        rf_wr_en   = 1'b0;
        rf_wr_addr = '0;
        rf_wr_data = '0;
        mul_start  = 1'b0;
        done       = 1'b0;
        vstart_clr = 1'b0;
        illegal    = 1'b0;
        gi_next    = {1'b0, q.gi} + 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!dec_legal) begin
                        d.st = ST_REJECT;
                    end else begin
                        d.mul_only = dec_mul;
                        d.vd       = dec_vd;
                        d.vs1      = dec_vs1;
                        d.vs2      = dec_vs2;
                        d.gi       = vstart[VL_W-1:2];
                        d.gend     = vl[VL_W-1:2];
                        d.st       = (vstart[VL_W-1:2] < vl[VL_W-1:2]) ? ST_ASK_ACC : ST_FINISH;
                    end
                end
            end
            ST_ASK_ACC: begin
                rf_rd_en   = 1'b1;
                rf_rd_addr = gaddr(q.vd, q.gi);
                d.st       = ST_TAKE_ACC;
            end
            ST_TAKE_ACC: begin
                d.acc    = rf_rd_data;
                rf_rd_en = 1'b1;
                if (q.mul_only) begin
                    d.dat      = '0;
                    rf_rd_addr = gaddr(q.vs2, q.gi);
                    d.st       = ST_TAKE_KEY;
                end else begin
                    rf_rd_addr = gaddr(q.vs1, q.gi);
                    d.st       = ST_TAKE_DAT;
                end
            end
            ST_TAKE_DAT: begin
                d.dat      = rf_rd_data;
                rf_rd_en   = 1'b1;
                rf_rd_addr = gaddr(q.vs2, q.gi);
                d.st       = ST_TAKE_KEY;
            end
            ST_TAKE_KEY: begin
                mul_start = 1'b1;
                d.st      = ST_MULT;
            end
            ST_MULT: begin
                if (mul_done) begin
                    rf_wr_en   = 1'b1;
                    rf_wr_addr = gaddr(q.vd, q.gi);
                    rf_wr_data = byte_bitrev(mul_z);
                    if (gi_next < {1'b0, q.gend}) begin
                        d.gi = gi_next[GI_W-1:0];
                        d.st = ST_ASK_ACC;
                    end else begin
                        d.st = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                done       = 1'b1;
                vstart_clr = 1'b1;
                d.st       = ST_IDLE;
            end
            ST_REJECT: begin
                illegal = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != ST_IDLE);
endmodule

// File: rtl/ghash_group_seq_chk.sv
module ghash_group_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] instr,
    input logic [2:0]  vsew,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic        vstart_clr,
    input logic        rf_rd_en,
    input logic        rf_wr_en
);
    logic enc_ok;
    always_comb begin
        enc_ok = (vsew == 3'b010) && (instr[6:0] == 7'b1110111) && (instr[14:12] == 3'b010) &&
                 ((instr[31:25] == 7'b1011001) ||
                  ((instr[31:25] == 7'b1010001) && (instr[19:15] == 5'b10001)));
    end

    assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !enc_ok) |=> (illegal && !done && !vstart_clr));

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && enc_ok) |=> (busy && !illegal));

    assert_idle_after_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !busy);

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_clear_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_clr |-> (done && busy));

    assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    assert_write_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> busy);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_wr_en, rf_rd_en, done, illegal}));
endmodule

bind ghash_group_seq ghash_group_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instr      (instr),
    .vsew       (vsew),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .vstart_clr (vstart_clr),
    .rf_rd_en   (rf_rd_en),
    .rf_wr_en   (rf_wr_en)
);

// File: tb/ghash_group_seq_tb.sv
module ghash_group_seq_tb;
    localparam int VLEN      = 256;
    localparam int GPR       = VLEN / 128;
    localparam int RF_GROUPS = 32 * GPR;
    localparam int ADDR_W    = $clog2(RF_GROUPS);
    localparam int VL_W      = $clog2(VLEN / 4) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic [2:0]        vsew = 3'b010;
    logic [VL_W-1:0]   vl = '0;
    logic [VL_W-1:0]   vstart = '0;
    logic              busy, done, illegal, vstart_clr;
    logic              rf_rd_en, rf_wr_en;
    logic [ADDR_W-1:0] rf_rd_addr, rf_wr_addr;
    logic [127:0]      rf_rd_data = '0;
    logic [127:0]      rf_wr_data;

    logic [127:0] rf     [RF_GROUPS];
    logic [127:0] ref_rf [RF_GROUPS];

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int ill_cnt = 0;
    int cycles = 0;
    string cur_req = "R5";
    logic [ADDR_W-1:0] exp_addr [$];
    logic [127:0]      exp_data [$];

    always #2 clk = ~clk;

    ghash_group_seq #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .vsew(vsew),
        .vl(vl), .vstart(vstart), .busy(busy), .done(done), .illegal(illegal),
        .vstart_clr(vstart_clr), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data)
    );

    always @(posedge clk) begin
        if (rf_rd_en) rf_rd_data <= rf[rf_rd_addr];
        if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rev8(input logic [127:0] v);
        logic [127:0] r;
        for (int by = 0; by < 16; by++)
            for (int bi = 0; bi < 8; bi++)
                r[8*by + bi] = v[8*by + 7 - bi];
        return r;
    endfunction

    function automatic logic [127:0] fmul(input logic [127:0] s, input logic [127:0] h);
        logic [127:0] acc = '0;
        logic [127:0] hh = h;
        for (int b = 0; b < 128; b++) begin
            if (s[b]) acc ^= hh;
            hh = hh[127] ? (({hh[126:0], 1'b0}) ^ 128'h87) : {hh[126:0], 1'b0};
        end
        return acc;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (illegal) ill_cnt++;
            if (rf_wr_en) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected write"}, 128'(rf_wr_addr), 128'hX);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    logic [127:0] ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(rf_wr_addr == ea, {cur_req, " R4 write address"}, 128'(rf_wr_addr), 128'(ea));
                    chk(rf_wr_data == ed, {cur_req, " write data"}, rf_wr_data, ed);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] enc_step(input int vd, input int vs1, input int vs2);
        return {7'b1011001, 5'(vs2), 5'(vs1), 3'b010, 5'(vd), 7'b1110111};
    endfunction
    function automatic logic [31:0] enc_mul(input int vd, input int vs2);
        return {7'b1010001, 5'(vs2), 5'b10001, 3'b010, 5'(vd), 7'b1110111};
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [2:0] sew, input int vlv, input int vst,
                          input bit legal, input bit intrude, input string req);
        int n = 0;
        int d0, i0, mism;
        cur_req = req;
        if (legal) begin
            bit mo = (ins[31:25] == 7'b1010001);
            int rd = int'(ins[11:7]);
            int r1 = int'(ins[19:15]);
            int r2 = int'(ins[24:20]);
            for (int g = vst / 4; g < vlv / 4; g++) begin
                int ad = rd * GPR + g;
                logic [127:0] x = mo ? 128'h0 : ref_rf[r1 * GPR + g];
                logic [127:0] res = rev8(fmul(rev8(ref_rf[ad] ^ x), rev8(ref_rf[r2 * GPR + g])));
                ref_rf[ad] = res;
                exp_addr.push_back(ADDR_W'(ad));
                exp_data.push_back(res);
            end
        end
        d0 = done_cnt;
        i0 = ill_cnt;
        @(negedge clk);
        instr = ins; vsew = sew; vl = VL_W'(vlv); vstart = VL_W'(vst); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            instr = 32'h0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || illegal) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (legal) begin
            chk(done && !illegal, {req, " R8 done pulse"}, 128'({done, illegal}), 128'b10);
            chk(vstart_clr, {req, " R8 vstart_clr with done"}, 128'(vstart_clr), 128'd1);
        end else begin
            chk(illegal && !done && !vstart_clr, {req, " R3 illegal pulse only"},
                128'({illegal, done, vstart_clr}), 128'b100);
        end
        @(negedge clk);
        chk(!busy, {req, " R8 idle after end"}, 128'(busy), 128'd0);
        chk(exp_addr.size() == 0, {req, " R4 all groups written"}, 128'(exp_addr.size()), 128'd0);
        chk(done_cnt - d0 == (legal ? 1 : 0), {req, " done count"}, 128'(done_cnt - d0), 128'(legal ? 1 : 0));
        if (intrude)
            chk(ill_cnt == i0, "R9 start while busy ignored", 128'(ill_cnt - i0), 128'd0);
        mism = 0;
        for (int i = 0; i < RF_GROUPS; i++) if (rf[i] !== ref_rf[i]) mism++;
        chk(mism == 0, {req, " R4 register file image"}, 128'(mism), 128'd0);
        exp_addr.delete();
        exp_data.delete();
    endtask

    initial begin
        for (int i = 0; i < RF_GROUPS; i++) begin
            rf[i] = {$urandom, $urandom, $urandom, $urandom};
            ref_rf[i] = rf[i];
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !illegal && !vstart_clr && !rf_wr_en && !rf_rd_en, "reset outputs",
            128'({busy, done, illegal, vstart_clr, rf_wr_en, rf_rd_en}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5: full-range hash step over two registers
        run_op(enc_step(4, 8, 12), 3'b010, 16, 0, 1'b1, 1'b0, "R5");
        // R4: unaligned start, partial end
        run_op(enc_step(4, 8, 12), 3'b010, 14, 5, 1'b1, 1'b0, "R4");
        // R2 R6: plain multiply
        run_op(enc_mul(16, 20), 3'b010, 8, 0, 1'b1, 1'b0, "R6");
        // R4 R6: maximum length spanning eight registers
        run_op(enc_mul(0, 16), 3'b010, 64, 4, 1'b1, 1'b0, "R6");
        // R7: empty ranges
        run_op(enc_step(4, 8, 12), 3'b010, 8, 8, 1'b1, 1'b0, "R7");
        run_op(enc_mul(16, 20), 3'b010, 4, 12, 1'b1, 1'b0, "R7");
        // R3: bad element width
        run_op(enc_step(4, 8, 12), 3'b011, 16, 0, 1'b0, 1'b0, "R3");
        // R2: plain multiply with a wrong source field
        run_op({7'b1010001, 5'd20, 5'b00000, 3'b010, 5'd16, 7'b1110111}, 3'b010, 8, 0, 1'b0, 1'b0, "R2");
        // R1: wrong opcode and wrong funct3
        run_op(enc_step(4, 8, 12) ^ 32'h1, 3'b010, 8, 0, 1'b0, 1'b0, "R1");
        run_op(enc_step(4, 8, 12) ^ 32'h1000, 3'b010, 8, 0, 1'b0, 1'b0, "R1");
        // R9: second start while a group is in flight
        run_op(enc_step(24, 2, 28), 3'b010, 16, 0, 1'b1, 1'b1, "R9");
        // R5 chain: accumulate a second time into the same destination (R10 writes spaced)
        run_op(enc_step(24, 2, 28), 3'b010, 12, 2, 1'b1, 1'b0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule